// File: doc/BRIEF.md
# Stereo Channel Panning Mixer

This block takes four unsigned 4-bit sound channel levels and mixes them into one left and one right sample. Two 8-bit registers are written over a simple write port and read back over a read port. The first register holds a 3-bit volume for each side and one stored flag per side. The second register gives each channel a separate enable for the left side and for the right side, so a channel can go to the left, the right, both sides or neither. All arithmetic is integer.

Each enabled channel is multiplied by its side's gain, which is the volume field plus one. The four products of a side are added together. When a one-cycle sample strobe arrives, the block captures both side sums and the eight per-channel products. In the two cycles that follow, it also sends the pair out on a tagged serial stream: the right sample first, then the left.

Top module: `stereo_pan_mixer`

## Requirements
- R1: After reset, both registers read 0, both side sums and all per-channel products are 0, and `streamValid` is low.
- R2: In the volume register, bits 6:4 are the left volume and bits 2:0 are the right volume. Bits 7 and 3 are stored and read back, but they have no effect on any mixed value.
- R3: In the routing register, bit i (i = 0..3) sends channel i to the right side and bit 4+i sends channel i to the left side. Channel i is taken from `chanLevels[4i+3:4i]`, with channel 0 in the lowest nibble.
- R4: The per-channel product for a side is the channel level times (volume field + 1), so the gain ranges from 1 to 8. Channel i's product is at `chanRight`/`chanLeft` bits [7i+6:7i].
- R5: A channel whose routing bit for a side is 0 gives a product of 0 on that side.
- R6: Each side sum is the sum of that side's four products. It is 9 bits wide and reaches 480 when all four levels are 15, the gain is 8 and all routing bits are set.
- R7: Sums and products are loaded only at a clock edge where `sampleStrobe` is high. They hold their value at every other edge, whatever the inputs do.
- R8: In the cycle after a strobe edge, `streamValid`=1, `streamLeft`=0 and `streamData` carries the new right sum. In the next cycle, `streamValid`=1, `streamLeft`=1 and `streamData` carries the left sum. After that, `streamValid`=0 unless another strobe arrives. A strobe that arrives while the left sample is pending starts a new pair.
- R9: Writing a register (`wrSel`=0 for volume, 1 for routing) stores all 8 bits. `rdData` then shows that register's full value when `rdSel` selects it.
- R10: A strobe in the same cycle as a register write mixes with the register values from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write enable |
| wrSel | input | 1 | Write target: 0 volume, 1 routing |
| wrData | input | 8 | Write data |
| rdSel | input | 1 | Read target: 0 volume, 1 routing |
| rdData | output | 8 | Read data of the selected register |
| sampleStrobe | input | 1 | One-cycle capture strobe |
| chanLevels | input | 16 | Four 4-bit channel levels, channel 0 lowest |
| rightSum | output | 9 | Registered right-side sum |
| leftSum | output | 9 | Registered left-side sum |
| chanRight | output | 28 | Registered right-side product of each channel, 7 bits each |
| chanLeft | output | 28 | Registered left-side product of each channel, 7 bits each |
| streamValid | output | 1 | Serial sample valid |
| streamLeft | output | 1 | Serial sample side: 0 right, 1 left |
| streamData | output | 9 | Serial sample value |

## Verification
The bench uses asymmetric volume and routing values, so a design that swapped the left and right fields, or the bit order within the routing register, would put values on the wrong side or the wrong channel lane. It checks the full-scale sum of 480 and the gain of 1 at volume 0. A design that dropped the +1 would output 0 at volume 0, and one with a narrow adder would wrap the full-scale sum. It sets the two stored flags and expects the same sums as without them. It changes the levels between strobes and expects the outputs to hold. It issues a strobe together with a write and expects the old register values to be used. It checks the right-then-left order of the stream and that the stream falls idle afterwards.

// File: rtl/mixer_pkg.sv
package mixer_pkg;
  parameter int NUM_CH = 4;
  parameter int CH_W   = 4;
  parameter int VOL_W  = 3;
  parameter int REG_W  = 8;
  localparam int GAIN_W = VOL_W + 1;
  localparam int PROD_W = CH_W + VOL_W;
  localparam int SUM_W  = PROD_W + $clog2(NUM_CH);

  typedef struct packed {
    logic capture;
    logic emitRight;
    logic emitLeft;
  } mixStrobes_t;
endpackage

// File: rtl/mixer_ctrl.sv
module mixer_ctrl
  import mixer_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             wrSel,
  input  logic [REG_W-1:0] wrData,
  input  logic             rdSel,
  input  logic             sampleStrobe,
  output logic [REG_W-1:0] rdData,
  output logic [REG_W-1:0] volReg,
  output logic [REG_W-1:0] routeReg,
  output mixStrobes_t      strobes
);
  logic pendLeft;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      volReg   <= '0;
      routeReg <= '0;
      pendLeft <= 1'b0;
    end else begin
      if (wrEn && !wrSel) volReg   <= wrData;
      if (wrEn &&  wrSel) routeReg <= wrData;
      pendLeft <= sampleStrobe;
    end
  end

  always_comb begin
    strobes.capture   = sampleStrobe;
    strobes.emitRight = sampleStrobe;
    strobes.emitLeft  = pendLeft && !sampleStrobe;
    rdData = rdSel ? routeReg : volReg;
  end
endmodule

// File: rtl/mixer_datapath.sv
module mixer_datapath
  import mixer_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  mixStrobes_t              strobes,
  input  logic [REG_W-1:0]         volReg,
  input  logic [REG_W-1:0]         routeReg,
  input  logic [NUM_CH*CH_W-1:0]   chanLevels,
  output logic [SUM_W-1:0]         rightSum,
  output logic [SUM_W-1:0]         leftSum,
  output logic [NUM_CH*PROD_W-1:0] chanRight,
  output logic [NUM_CH*PROD_W-1:0] chanLeft,
  output logic                     streamValid,
  output logic                     streamLeft,
  output logic [SUM_W-1:0]         streamData
);
  localparam int HALF = REG_W / 2;

  logic [GAIN_W-1:0] gainRight, gainLeft;
  logic [PROD_W-1:0] prodRight [NUM_CH];
  logic [PROD_W-1:0] prodLeft  [NUM_CH];
  logic [SUM_W-1:0]  nextRight, nextLeft;

  assign gainRight = GAIN_W'(volReg[VOL_W-1:0]) + GAIN_W'(1);
  assign gainLeft  = GAIN_W'(volReg[HALF+VOL_W-1:HALF]) + GAIN_W'(1);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    logic [CH_W-1:0] level;
    assign level = chanLevels[i*CH_W +: CH_W];
    assign prodRight[i] = routeReg[i] ?
        PROD_W'(PROD_W'(level) * PROD_W'(gainRight)) : '0;
    assign prodLeft[i]  = routeReg[HALF+i] ?
        PROD_W'(PROD_W'(level) * PROD_W'(gainLeft)) : '0;
  end

  always_comb begin
    nextRight = '0;
    nextLeft  = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      nextRight = nextRight + SUM_W'(prodRight[i]);
      nextLeft  = nextLeft  + SUM_W'(prodLeft[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rightSum  <= '0;
      leftSum   <= '0;
      chanRight <= '0;
      chanLeft  <= '0;
    end else if (strobes.capture) begin
      rightSum <= nextRight;
      leftSum  <= nextLeft;
      for (int i = 0; i < NUM_CH; i++) begin
        chanRight[i*PROD_W +: PROD_W] <= prodRight[i];
        chanLeft[i*PROD_W +: PROD_W]  <= prodLeft[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      streamValid <= 1'b0;
      streamLeft  <= 1'b0;
      streamData  <= '0;
    end else if (strobes.emitRight) begin
      streamValid <= 1'b1;
      streamLeft  <= 1'b0;
      streamData  <= nextRight;
    end else if (strobes.emitLeft) begin
      streamValid <= 1'b1;
      streamLeft  <= 1'b1;
      streamData  <= leftSum;
    end else begin
      streamValid <= 1'b0;
    end
  end
endmodule

// File: rtl/stereo_pan_mixer.sv
module stereo_pan_mixer
  import mixer_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     wrEn,
  input  logic                     wrSel,
  input  logic [REG_W-1:0]         wrData,
  input  logic                     rdSel,
  output logic [REG_W-1:0]         rdData,
  input  logic                     sampleStrobe,
  input  logic [NUM_CH*CH_W-1:0]   chanLevels,
  output logic [SUM_W-1:0]         rightSum,
  output logic [SUM_W-1:0]         leftSum,
  output logic [NUM_CH*PROD_W-1:0] chanRight,
  output logic [NUM_CH*PROD_W-1:0] chanLeft,
  output logic                     streamValid,
  output logic                     streamLeft,
  output logic [SUM_W-1:0]         streamData
);
  mixStrobes_t      strobes;
  logic [REG_W-1:0] volReg, routeReg;

  mixer_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .rdSel(rdSel), .sampleStrobe(sampleStrobe), .rdData(rdData),
    .volReg(volReg), .routeReg(routeReg), .strobes(strobes)
  );

  mixer_datapath i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .volReg(volReg),
    .routeReg(routeReg), .chanLevels(chanLevels), .rightSum(rightSum),
    .leftSum(leftSum), .chanRight(chanRight), .chanLeft(chanLeft),
    .streamValid(streamValid), .streamLeft(streamLeft), .streamData(streamData)
  );
endmodule

// File: rtl/mixer_checker.sv
module mixer_checker
  import mixer_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic             wrSel,
  input logic [REG_W-1:0] wrData,
  input logic             rdSel,
  input logic [REG_W-1:0] rdData,
  input logic             sampleStrobe,
  input logic [SUM_W-1:0] rightSum,
  input logic [SUM_W-1:0] leftSum,
  input logic             streamValid,
  input logic             streamLeft,
  input logic [SUM_W-1:0] streamData
);
  localparam int MAX_SUM = NUM_CH * ((1 << CH_W) - 1) * (1 << VOL_W);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (int'(rightSum) <= MAX_SUM) && (int'(leftSum) <= MAX_SUM)); // R6

  AST_HOLD_SUMS: assert property (@(posedge clk) disable iff (!rstN)
    !sampleStrobe |=> $stable(rightSum) && $stable(leftSum)); // R7

  AST_RIGHT_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    sampleStrobe |=> streamValid && !streamLeft && streamData == rightSum); // R8

  AST_LEFT_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    (streamValid && !streamLeft && !sampleStrobe) |=>
      streamValid && streamLeft && streamData == leftSum); // R8

  AST_STREAM_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (streamValid && streamLeft && !sampleStrobe) |=> !streamValid); // R8

  AST_READBACK: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (rdSel != $past(wrSel)) || (rdData == $past(wrData))); // R9
endmodule

bind stereo_pan_mixer mixer_checker i_checker (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
  .rdSel(rdSel), .rdData(rdData), .sampleStrobe(sampleStrobe),
  .rightSum(rightSum), .leftSum(leftSum), .streamValid(streamValid),
  .streamLeft(streamLeft), .streamData(streamData)
);

// File: tb/test_stereo_pan_mixer.sv
module test_stereo_pan_mixer;
  logic        clk = 0;
  logic        rstN = 0;
  logic        wrEn = 0, wrSel = 0, rdSel = 0, sampleStrobe = 0;
  logic [7:0]  wrData = 0;
  logic [7:0]  rdData;
  logic [15:0] chanLevels = 0;
  logic [8:0]  rightSum, leftSum, streamData;
  logic [27:0] chanRight, chanLeft;
  logic        streamValid, streamLeft;
  int total = 0, bad = 0;
  logic [7:0] curVol = 0, curRoute = 0;

  always #5 clk = ~clk;

  stereo_pan_mixer i_stereo_pan_mixer (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .rdSel(rdSel), .rdData(rdData), .sampleStrobe(sampleStrobe),
    .chanLevels(chanLevels), .rightSum(rightSum), .leftSum(leftSum),
    .chanRight(chanRight), .chanLeft(chanLeft), .streamValid(streamValid),
    .streamLeft(streamLeft), .streamData(streamData)
  );

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int prod(logic [7:0] v, logic [7:0] r, logic [15:0] lv,
                              int ch, bit left);
    int gain = left ? int'(v[6:4]) + 1 : int'(v[2:0]) + 1;
    bit en = left ? r[4+ch] : r[ch];
    return en ? int'(lv[4*ch +: 4]) * gain : 0;
  endfunction

  function automatic int side(logic [7:0] v, logic [7:0] r, logic [15:0] lv, bit left);
    int s = 0;
    for (int c = 0; c < 4; c++) s += prod(v, r, lv, c, left);
    return s;
  endfunction

  task automatic writeReg(bit sel, logic [7:0] d);
    @(negedge clk); wrEn = 1; wrSel = sel; wrData = d;
    @(negedge clk); wrEn = 0;
    if (sel) curRoute = d; else curVol = d;
  endtask

  task automatic strobeAndCheck(string req, logic [15:0] lv);
    int expR, expL;
    @(negedge clk); chanLevels = lv; sampleStrobe = 1;
    expR = side(curVol, curRoute, lv, 0);
    expL = side(curVol, curRoute, lv, 1);
    @(negedge clk); sampleStrobe = 0;
    check({req, " rightSum"}, rightSum, expR);
    check({req, " leftSum"}, leftSum, expL);
    for (int c = 0; c < 4; c++) begin
      check({req, " R4 chanRight"}, chanRight[7*c +: 7], prod(curVol, curRoute, lv, c, 0));
      check({req, " R4 chanLeft"}, chanLeft[7*c +: 7], prod(curVol, curRoute, lv, c, 1));
    end
    check("R8 right valid", {streamValid, streamLeft}, 2);
    check("R8 right data", streamData, expR);
    @(negedge clk);
    check("R8 left valid", {streamValid, streamLeft}, 3);
    check("R8 left data", streamData, expL);
    @(negedge clk);
    check("R8 idle", streamValid, 0);
  endtask

  task automatic testReset();
    rdSel = 0; #1; check("R1 vol", rdData, 0);
    rdSel = 1; #1; check("R1 route", rdData, 0);
    check("R1 sums", {rightSum, leftSum}, 0);
    check("R1 prods", int'(|{chanRight, chanLeft}), 0);
    check("R1 stream", streamValid, 0);
  endtask

  task automatic testReadback();
    writeReg(0, 8'hA5); rdSel = 0; #1; check("R9 vol readback", rdData, 8'hA5);
    writeReg(1, 8'h3C); rdSel = 1; #1; check("R9 route readback", rdData, 8'h3C);
    rdSel = 0; #1; check("R9 vol kept", rdData, 8'hA5);
  endtask

  task automatic testAsymmetric();
    writeReg(0, 8'h52);   // left 5 -> gain 6, right 2 -> gain 3
    writeReg(1, 8'h96);   // left ch0,ch3 ; right ch1,ch2
    strobeAndCheck("R2 R3 asym", 16'h4937);
    writeReg(1, 8'h18);   // left ch0 only, right ch3 only
    strobeAndCheck("R3 R5 single", 16'hF00E);
  endtask

  task automatic testGain();
    writeReg(0, 8'h00); writeReg(1, 8'hFF);
    strobeAndCheck("R4 gain1", 16'h1234);
    writeReg(0, 8'h77);
    strobeAndCheck("R6 fullscale", 16'hFFFF);
    check("R6 max 480", rightSum, 480);
  endtask

  task automatic testFlags();
    int r0, l0;
    writeReg(0, 8'h36); writeReg(1, 8'hA5);
    strobeAndCheck("R2 noflags", 16'h8C3A);
    r0 = rightSum; l0 = leftSum;
    writeReg(0, 8'hBE);
    strobeAndCheck("R2 flags", 16'h8C3A);
    check("R2 flag right", rightSum, r0);
    check("R2 flag left", leftSum, l0);
  endtask

  task automatic testNoRoute();
    writeReg(0, 8'h77); writeReg(1, 8'h00);
    strobeAndCheck("R5 none", 16'hFFFF);
  endtask

  task automatic testHold();
    int r0, l0;
    writeReg(0, 8'h43); writeReg(1, 8'hFF);
    strobeAndCheck("R7 base", 16'h2222);
    r0 = rightSum; l0 = leftSum;
    @(negedge clk); chanLevels = 16'hFFFF;
    writeReg(0, 8'h77);
    repeat (3) @(negedge clk);
    check("R7 hold right", rightSum, r0);
    check("R7 hold left", leftSum, l0);
  endtask

  task automatic testWriteWithStrobe();
    int expR;
    writeReg(0, 8'h11); writeReg(1, 8'h0F);
    expR = side(8'h11, 8'h0F, 16'h5555, 0);
    @(negedge clk); chanLevels = 16'h5555; sampleStrobe = 1;
    wrEn = 1; wrSel = 0; wrData = 8'h77;
    @(negedge clk); sampleStrobe = 0; wrEn = 0; curVol = 8'h77;
    check("R10 old regs used", rightSum, expR);
    repeat (2) @(negedge clk);
  endtask

  task automatic testBackToBack();
    writeReg(0, 8'h21); writeReg(1, 8'hF3);
    @(negedge clk); chanLevels = 16'h1111; sampleStrobe = 1;
    @(negedge clk); chanLevels = 16'h3333;
    @(negedge clk); sampleStrobe = 0;
    check("R8 restart right", {streamValid, streamLeft}, 2);
    check("R8 restart data", streamData, side(curVol, curRoute, 16'h3333, 0));
    @(negedge clk);
    check("R8 restart left", streamData, side(curVol, curRoute, 16'h3333, 1));
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testReadback();
    testAsymmetric();
    testGain();
    testFlags();
    testNoRoute();
    testHold();
    testWriteWithStrobe();
    testBackToBack();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule